// File: doc/BRIEF.md
# SMBus Register-Access Transaction Decoder

This block is the transaction layer of an SMBus slave. It sits behind a bit-level front end that handles the SDA/SCL pins. The front end reports each start (first or repeated), each stop and each received byte. It asks for the next byte to transmit and reports each master ACK. The decoder then decides whether to ACK each received byte. It interprets the command byte, keeps the access pointer, and issues single-byte and block writes. It also supplies the bytes for single-byte and block reads, and can request a page erase.

One command byte carries several meanings:
- 0x00–0xDF: a volatile register address.
- 0xF8–0xFB: the high half of a 16-bit nonvolatile address, with the low half in the next byte.
- 0xFC, 0xFD, 0xFE: the opcodes for block write, block read and page erase.

A block read always reports a count of 32. When enabled, it is followed by a CRC-8 packet error code.

The memory arrays are outside the block. The block presents one address. Read data for that address returns combinationally, and writes are single-cycle strobes.

Top module: `smb_xact_decoder`

## Requirements
- R1: The slave answers only to the 7-bit address {00111, dev_sel_i[1:0]}, that is, 0x1C to 0x1F. The address byte is the 7-bit address followed by the R/W bit (1 = read). Every other address byte is NACKed. ack_o is updated only in the cycle after rx_vld_i and holds otherwise.
- R2: A write command byte in 0x00–0xDF loads the pointer with {0x00, command} and is ACKed. A transaction that stops there changes nothing else.
- R3: After a command of 0x00–0xDF, exactly one data byte is written to that RAM address and ACKed. Any further byte in the same transaction is NACKed and produces no write.
- R4: A command of 0xF8–0xFB is ACKed and latched as the high address byte. The next byte is the low byte, and the pointer becomes {high, low}. An optional third byte is written at that pointer. A fourth byte is NACKed.
- R5: Command 0xFC is a block write. A count byte of 1..32 is ACKed, and that many data bytes are written from the pointer, which increments after each byte. A count of 0 or above 32 is NACKed.
- R6: After command 0xFD, a repeated start with a read address begins a block read. The slave sends 0x20, then 32 data bytes from the pointer, incrementing the pointer after each one.
- R7: A read transaction that does not follow 0xFD returns the single byte at the pointer and leaves the pointer unchanged.
- R8: Command 0xFE issues a one-cycle erase strobe at the pointer and is ACKed when the pointer lies in the nonvolatile space (high byte 0xF8–0xFB). Otherwise it is NACKed and no strobe is issued.
- R9: Command bytes 0xE0–0xF7 and 0xFF are NACKed.
- R10: While erase_busy_i is high, the address byte is NACKed even when it matches.
- R11: With pec_en_i high, a block read sends one more byte after its 32nd data byte. That byte is the CRC-8 (polynomial 0x07, initial value 0x00, MSB first) of every byte of the transaction: the write address byte, 0xFD, the read address byte, the count and the data. With pec_en_i low, the slave sends 0xFF there instead.
- R12: Data read at volatile addresses 0xE0–0xFF (high byte 0x00) is 0x00, whatever the memory returns.
- R13: After reset, ack_o is 0, no write or erase strobe is active, and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel_i | input | 2 | Low two bits of the slave address |
| start_i | input | 1 | Start or repeated start strobe |
| stop_i | input | 1 | Stop strobe |
| rx_vld_i | input | 1 | Received-byte strobe |
| rx_byte_i | input | 8 | Received byte |
| ack_o | output | 1 | ACK decision for the last received byte |
| tx_adv_i | input | 1 | Current transmit byte sent and ACKed by the master |
| tx_byte_o | output | 8 | Byte to transmit next |
| pec_en_i | input | 1 | Append PEC after block read |
| mem_addr_o | output | 16 | Access pointer (read and write address) |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| rd_data_i | input | 8 | Read data at mem_addr_o |
| erase_o | output | 1 | Page erase strobe |
| erase_busy_i | input | 1 | Erase in progress |

## Verification
Every one of the 128 slave addresses is tried, and every reserved command value is swept. A decoder that compared too few address bits would ACK a neighbour's address. One that fell through on an unassigned command would silently reload the pointer.

Block write counts are probed at 0, 32 and 33. An off-by-one boundary would either accept an overlong block or refuse a legal full one.

A block read is started just below the unmapped register gap, so the 32 bytes cross into it. A wrong increment, or a missing zero mask, shows up as a mismatch at the exact byte.

The PEC byte is compared against a CRC computed bit-serially in the bench. Leaving out the repeated-start address byte, or the count, changes the value. Erase is checked both with a volatile pointer, which must be refused, and with a busy flag, which must NACK the address.

// File: rtl/smb_pkg.sv
// Shared types and the CRC-8 step function for the SMBus transaction decoder.
// Assumes bytes are shifted MSB first, as on the wire.
package smb_pkg;

    localparam int AW = 16;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_CMD, S_RAMD, S_EELO, S_EED, S_BWCNT, S_BWD, S_RD, S_HOLD
    } xst_t;

    typedef enum logic [1:0] {T_CNT, T_DATA, T_PEC, T_END} txp_t;

    // One byte through CRC-8, polynomial x^8+x^2+x+1
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/smb_crc8.sv
// Running CRC-8 over transaction bytes.
// Assumes clr and feed never arrive in the same cycle; clr wins if they do.
module smb_crc8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       feed,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import smb_pkg::*;

    // Accumulate one byte per feed strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= 8'h00;
        else if (feed)     crc <= crc8_step(crc, din);
    end
endmodule

// File: rtl/smb_ptr.sv
// Access pointer: loadable, auto-incrementing.
// Assumes ld and inc are mutually exclusive; ld wins otherwise.
module smb_ptr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] ptr
);
    // Load or step the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (ld)  ptr <= ld_val;
        else if (inc) ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/smb_xact_decoder.sv
// SMBus slave transaction decoder: address match, command decode, pointer,
// single and block accesses, optional PEC on block reads.
// Assumes the front end gives one-cycle strobes, samples ack_o one cycle
// after rx_vld_i, and reads tx_byte_o while no tx_adv_i is pending.
module smb_xact_decoder #(
    parameter logic [4:0] ADDR_HI  = 5'b00111,
    parameter logic [7:0] RAM_TOP  = 8'hDF,
    parameter logic [7:0] NV_LO    = 8'hF8,
    parameter logic [7:0] NV_HI    = 8'hFB,
    parameter logic [7:0] OP_BWR   = 8'hFC,
    parameter logic [7:0] OP_BRD   = 8'hFD,
    parameter logic [7:0] OP_ERS   = 8'hFE,
    parameter int         BLK_MAX  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             dev_sel_i,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic                   rx_vld_i,
    input  logic [7:0]             rx_byte_i,
    output logic                   ack_o,
    input  logic                   tx_adv_i,
    output logic [7:0]             tx_byte_o,
    input  logic                   pec_en_i,
    output logic [smb_pkg::AW-1:0] mem_addr_o,
    output logic                   mem_we_o,
    output logic [7:0]             mem_wdata_o,
    input  logic [7:0]             rd_data_i,
    output logic                   erase_o,
    input  logic                   erase_busy_i
);
    import smb_pkg::*;

    localparam int             CW        = $clog2(BLK_MAX + 1);
    localparam logic [7:0]     BLK_B     = 8'(BLK_MAX);
    localparam logic [CW-1:0]  LAST_BEAT = CW'(BLK_MAX - 1);

    xst_t          st;
    txp_t          txp;
    logic          blk_pend, single_rd;
    logic [7:0]    hi_q;
    logic [CW-1:0] cnt_q, beat_q;
    logic [AW-1:0] ptr;
    logic [7:0]    crc;
    logic          addr_match, ptr_nv, rd_unmapped, cmd_nv;
    logic          ptr_ld, ptr_inc, crc_feed;
    logic [AW-1:0] ptr_val;

    // Address and pointer-space decode
    always_comb begin
        addr_match  = rx_byte_i[7:1] == {ADDR_HI, dev_sel_i};
        ptr_nv      = ptr[15:8] >= NV_LO && ptr[15:8] <= NV_HI;
        rd_unmapped = ptr[15:8] == 8'h00 && ptr[7:0] > RAM_TOP;
        cmd_nv      = rx_byte_i >= NV_LO && rx_byte_i <= NV_HI;
    end

    // Memory strobes driven straight from the received byte
    always_comb begin
        mem_addr_o  = ptr;
        mem_wdata_o = rx_byte_i;
        mem_we_o    = rx_vld_i && !start_i && !stop_i &&
                      (st == S_RAMD || st == S_EED || st == S_BWD);
        erase_o     = rx_vld_i && !start_i && !stop_i && st == S_CMD &&
                      rx_byte_i == OP_ERS && ptr_nv;
    end

    // Pointer load and increment requests
    always_comb begin
        ptr_ld  = 1'b0;
        ptr_val = {8'h00, rx_byte_i};
        if (rx_vld_i && !start_i && !stop_i) begin
            if (st == S_CMD && rx_byte_i <= RAM_TOP) ptr_ld = 1'b1;
            if (st == S_EELO) begin
                ptr_ld  = 1'b1;
                ptr_val = {hi_q, rx_byte_i};
            end
        end
        ptr_inc = (mem_we_o && st == S_BWD) ||
                  (tx_adv_i && !start_i && !stop_i && st == S_RD &&
                   txp == T_DATA && !single_rd);
    end

    // Transmit byte selection
    always_comb begin
        case (txp)
            T_CNT:   tx_byte_o = BLK_B;
            T_DATA:  tx_byte_o = rd_unmapped ? 8'h00 : rd_data_i;
            T_PEC:   tx_byte_o = crc;
            default: tx_byte_o = 8'hFF;
        endcase
    end

    // CRC feed: every received byte and every sent count or data byte
    always_comb begin
        crc_feed = (rx_vld_i && st != S_IDLE) ||
                   (tx_adv_i && st == S_RD && (txp == T_CNT || txp == T_DATA));
    end

    smb_ptr #(.W(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .ld_val(ptr_val),
        .inc(ptr_inc), .ptr(ptr)
    );

    smb_crc8 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(start_i && st == S_IDLE),
        .feed(crc_feed), .din(rx_vld_i ? rx_byte_i : tx_byte_o), .crc(crc)
    );

    // Transaction state machine and ACK decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; txp <= T_END; blk_pend <= 1'b0; single_rd <= 1'b0;
            hi_q <= 8'h00; cnt_q <= '0; beat_q <= '0; ack_o <= 1'b0;
        end else if (stop_i) begin
            st <= S_IDLE; blk_pend <= 1'b0;
        end else if (start_i) begin
            st <= S_ADDR;
            if (st == S_IDLE) blk_pend <= 1'b0;
        end else if (rx_vld_i) begin
            case (st)
                S_ADDR: begin
                    if (addr_match && !erase_busy_i) begin
                        ack_o <= 1'b1;
                        if (rx_byte_i[0]) begin
                            st        <= S_RD;
                            single_rd <= !blk_pend;
                            txp       <= blk_pend ? T_CNT : T_DATA;
                            beat_q    <= '0;
                            blk_pend  <= 1'b0;
                        end else begin
                            st <= S_CMD;
                        end
                    end else begin
                        ack_o <= 1'b0;
                        st    <= S_HOLD;
                    end
                end
                S_CMD: begin
                    ack_o <= 1'b1;
                    st    <= S_HOLD;
                    if (rx_byte_i <= RAM_TOP) st <= S_RAMD;
                    else if (cmd_nv) begin
                        hi_q <= rx_byte_i;
                        st   <= S_EELO;
                    end
                    else if (rx_byte_i == OP_BWR) st <= S_BWCNT;
                    else if (rx_byte_i == OP_BRD) blk_pend <= 1'b1;
                    else if (rx_byte_i == OP_ERS) ack_o <= ptr_nv;
                    else ack_o <= 1'b0;
                end
                S_RAMD: begin ack_o <= 1'b1; st <= S_HOLD; end
                S_EELO: begin ack_o <= 1'b1; st <= S_EED;  end
                S_EED:  begin ack_o <= 1'b1; st <= S_HOLD; end
                S_BWCNT: begin
                    if (rx_byte_i != 8'h00 && rx_byte_i <= BLK_B) begin
                        ack_o <= 1'b1;
                        cnt_q <= rx_byte_i[CW-1:0];
                        st    <= S_BWD;
                    end else begin
                        ack_o <= 1'b0;
                        st    <= S_HOLD;
                    end
                end
                S_BWD: begin
                    ack_o <= 1'b1;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) st <= S_HOLD;
                end
                default: ack_o <= 1'b0;
            endcase
        end else if (tx_adv_i && st == S_RD) begin
            case (txp)
                T_CNT:  txp <= T_DATA;
                T_DATA: begin
                    beat_q <= beat_q + 1'b1;
                    if (single_rd)                txp <= T_END;
                    else if (beat_q == LAST_BEAT) txp <= pec_en_i ? T_PEC : T_END;
                end
                default: txp <= T_END;
            endcase
        end
    end

    // ACK decision moves only in the cycle after a received byte
    assert_ack_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld_i |=> $stable(ack_o));

    // Busy erase forces a NACK of the address phase
    assert_busy_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld_i && st == S_ADDR && erase_busy_i && !start_i && !stop_i) |=> !ack_o);

    // An issued erase is always acknowledged
    assert_erase_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_o && !start_i && !stop_i) |=> ack_o);

    // Block write remaining count stays in 1..BLK_MAX
    assert_bw_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_BWD |-> (cnt_q != '0 && cnt_q <= CW'(BLK_MAX)));

    // No write strobe while transmitting
    assert_no_write_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_RD |-> !mem_we_o);

    // Block read beat counter never passes the last beat while sending data
    assert_beat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD && txp == T_DATA && !single_rd) |-> beat_q <= LAST_BEAT);

endmodule

// File: tb/sim_smb_xact_decoder.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural memories, address and command sweeps,
// block transfers and PEC computed bit-serially.
module sim_smb_xact_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dev_sel = 2'd2;
    logic        start_i = 0, stop_i = 0, rx_vld = 0, tx_adv = 0, pec_en = 0, busy = 0;
    logic [7:0]  rx_byte = 8'h00;
    logic        ack_o, mem_we, erase;
    logic [7:0]  tx_byte, wdata, rdata;
    logic [15:0] maddr;
    int          total = 0, bad = 0, er_cnt = 0;
    logic [15:0] er_addr = 16'h0;
    logic [7:0]  ram [256];
    logic [7:0]  ee  [1024];

    always #4 clk = ~clk;

    smb_xact_decoder u0 (
        .clk(clk), .rst_n(rst_n), .dev_sel_i(dev_sel), .start_i(start_i),
        .stop_i(stop_i), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte), .ack_o(ack_o),
        .tx_adv_i(tx_adv), .tx_byte_o(tx_byte), .pec_en_i(pec_en),
        .mem_addr_o(maddr), .mem_we_o(mem_we), .mem_wdata_o(wdata),
        .rd_data_i(rdata), .erase_o(erase), .erase_busy_i(busy)
    );

    assign rdata = (maddr[15:8] == 8'h00) ? ram[maddr[7:0]] : ee[maddr[9:0]];

    always @(posedge clk) begin
        if (mem_we) begin
            if (maddr[15:8] == 8'h00) ram[maddr[7:0]] <= wdata;
            else                      ee[maddr[9:0]]  <= wdata;
        end
        if (erase) begin er_cnt <= er_cnt + 1; er_addr <= maddr; end
    end

    function automatic logic [7:0] crc_bits(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_start; @(negedge clk) start_i = 1; @(negedge clk) start_i = 0; endtask
    task automatic do_stop;  @(negedge clk) stop_i = 1;  @(negedge clk) stop_i = 0;  endtask

    task automatic wr(input logic [7:0] b, output logic a);
        @(negedge clk) rx_vld = 1; rx_byte = b;
        @(negedge clk) rx_vld = 0; a = ack_o;
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk) b = tx_byte; tx_adv = 1;
        @(negedge clk) tx_adv = 0;
    endtask

    // Set RAM pointer with a send byte
    task automatic set_ram(input logic [7:0] a);
        logic k;
        do_start; wr(8'h3C, k); wr(a, k); do_stop;
    endtask

    task automatic recv(output logic [7:0] b);
        logic k;
        do_start; wr(8'h3D, k); rd(b); do_stop;
    endtask

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up;
    end

    initial begin
        logic a;
        logic [7:0] b, c;
        for (int i = 0; i < 256; i++)  ram[i] = 8'(i) ^ 8'h5A;
        for (int i = 0; i < 1024; i++) ee[i]  = 8'hFF;
        repeat (4) @(negedge clk);
        chk("R13 ack", int'(ack_o), 0);
        chk("R13 ptr", int'(maddr), 0);
        chk("R13 strobes", int'({mem_we, erase}), 0);
        rst_n = 1;

        // R1: full address sweep, write direction
        for (int ad = 0; ad < 128; ad++) begin
            do_start; wr({7'(ad), 1'b0}, a); do_stop;
            chk("R1 addr sweep", int'(a), int'(ad == 7'h1E));
        end
        dev_sel = 2'd1;
        do_start; wr(8'h3A, a); do_stop; chk("R1 sel1 match", int'(a), 1);
        do_start; wr(8'h3C, a); do_stop; chk("R1 sel1 other", int'(a), 0);
        dev_sel = 2'd2;

        // R9: reserved commands
        for (int cm = 8'hE0; cm <= 8'hFF; cm++) begin
            if (cm >= 8'hF8 && cm <= 8'hFE) continue;
            do_start; wr(8'h3C, a); wr(8'(cm), a); do_stop;
            chk("R9 reserved cmd nack", int'(a), 0);
        end

        // R2 and R7: send byte then receive twice
        set_ram(8'h40);
        chk("R2 ptr load", int'(maddr), 16'h0040);
        recv(b); chk("R2 recv", int'(b), 8'h40 ^ 8'h5A);
        recv(b); chk("R7 ptr unchanged", int'(b), 8'h40 ^ 8'h5A);
        chk("R7 ptr value", int'(maddr), 16'h0040);

        // R3: write byte, extra byte refused
        do_start; wr(8'h3C, a); wr(8'h41, a); wr(8'h99, a);
        chk("R3 data ack", int'(a), 1);
        wr(8'h77, a); chk("R3 extra nack", int'(a), 0); do_stop;
        set_ram(8'h41); recv(b); chk("R3 written", int'(b), 8'h99);
        set_ram(8'h42); recv(b); chk("R3 no extra write", int'(b), 8'h42 ^ 8'h5A);

        // R4: EEPROM address set, then program
        do_start; wr(8'h3C, a); wr(8'hF9, a); chk("R4 hi ack", int'(a), 1);
        wr(8'h10, a); do_stop;
        chk("R4 ptr", int'(maddr), 16'hF910);
        recv(b); chk("R4 blank", int'(b), 8'hFF);
        do_start; wr(8'h3C, a); wr(8'hF9, a); wr(8'h10, a); wr(8'hAB, a);
        wr(8'h01, a); chk("R4 fourth nack", int'(a), 0); do_stop;
        recv(b); chk("R4 programmed", int'(b), 8'hAB);
        chk("R4 neighbour", int'(ee[10'h111]), 8'hFF);

        // R5: block write
        set_ram(8'h20);
        do_start; wr(8'h3C, a); wr(8'hFC, a); wr(8'd4, a);
        chk("R5 count ack", int'(a), 1);
        for (int k = 0; k < 4; k++) begin
            wr(8'hC0 + 8'(k), a); chk("R5 data ack", int'(a), 1);
        end
        wr(8'h55, a); chk("R5 extra nack", int'(a), 0); do_stop;
        for (int k = 0; k < 4; k++) chk("R5 block data", int'(ram[8'h20 + k]), 8'hC0 + k);
        chk("R5 no overrun", int'(ram[8'h24]), 8'h24 ^ 8'h5A);
        do_start; wr(8'h3C, a); wr(8'hFC, a); wr(8'd0, a); do_stop;
        chk("R5 count0 nack", int'(a), 0);
        do_start; wr(8'h3C, a); wr(8'hFC, a); wr(8'd33, a); do_stop;
        chk("R5 count33 nack", int'(a), 0);
        do_start; wr(8'h3C, a); wr(8'hFC, a); wr(8'd32, a); do_stop;
        chk("R5 count32 ack", int'(a), 1);

        // R6, R11, R12: block read across the unmapped gap with PEC
        pec_en = 1;
        set_ram(8'hD0);
        c = 8'h00;
        do_start; wr(8'h3C, a); c = crc_bits(c, 8'h3C); wr(8'hFD, a); c = crc_bits(c, 8'hFD);
        chk("R6 fd ack", int'(a), 1);
        do_start; wr(8'h3D, a); c = crc_bits(c, 8'h3D);
        rd(b); c = crc_bits(c, b); chk("R6 count", int'(b), 8'h20);
        for (int k = 0; k < 32; k++) begin
            rd(b); c = crc_bits(c, b);
            if (k < 16) chk("R6 block data", int'(b), (8'hD0 + k) ^ 8'h5A);
            else        chk("R12 unmapped zero", int'(b), 0);
        end
        rd(b); chk("R11 pec", int'(b), int'(c));
        do_stop;
        pec_en = 0;
        set_ram(8'h00);
        do_start; wr(8'h3C, a); wr(8'hFD, a); do_start; wr(8'h3D, a);
        rd(b);
        for (int k = 0; k < 32; k++) rd(b);
        chk("R11 no pec when off", int'(tx_byte), 8'hFF);
        do_stop;

        // R8: erase refused on RAM pointer, accepted on nonvolatile pointer
        set_ram(8'h40);
        do_start; wr(8'h3C, a); wr(8'hFE, a); do_stop;
        chk("R8 ram nack", int'(a), 0);
        chk("R8 no strobe", er_cnt, 0);
        do_start; wr(8'h3C, a); wr(8'hFA, a); wr(8'h25, a); do_stop;
        do_start; wr(8'h3C, a); wr(8'hFE, a); do_stop;
        chk("R8 nv ack", int'(a), 1);
        chk("R8 one strobe", er_cnt, 1);
        chk("R8 erase addr", int'(er_addr), 16'hFA25);

        // R10: busy NACKs the address
        busy = 1;
        do_start; wr(8'h3C, a); do_stop; chk("R10 busy nack", int'(a), 0);
        busy = 0;
        do_start; wr(8'h3C, a); do_stop; chk("R10 idle ack", int'(a), 1);

        finish_up;
    end
endmodule